// File: doc/BRIEF.md
# DMA Interrupt Cause Collector

This block collects the interrupt causes of a ten-channel DMA controller into one 32-bit word and drives a single level interrupt request toward the CPU. Every channel sends a one-cycle completion pulse. The controller also raises one-cycle pulses for a stall, for the memory FIFO running empty and for a bus error. Each pulse sets a sticky status bit, which keeps its value until software clears it.

The word also holds the enable bits that decide which causes reach the interrupt line. The status half and the enable half share one address, but a write treats them differently. A 1 written to a status bit clears that bit. A 1 written to an enable bit inverts that bit. A 0 leaves either kind of bit unchanged. This lets software acknowledge causes and adjust the mask without a read-modify-write sequence. A bus error raises the interrupt whatever the enables hold.

The read port is a combinational view of the registers. A pulse or a write captured at a clock edge is visible right after that edge, and so is its effect on the interrupt line.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A pulse on `ch_done[n]` sets status bit n (bits 9..0) from the next clock edge on, and the bit stays set while no write clears it.
- R2: Pulses on `stall_evt`, `fifo_empty_evt` and `bus_err_evt` set status bits 13, 14 and 15 respectively, and those bits are sticky.
- R3: A write clears every status bit (9..0, 13, 14, 15) whose data bit is 1 and leaves the status bits written as 0 unchanged.
- R4: A write inverts every enable bit whose data bit is 1. Channel n's enable is bit 16+n, the stall enable is bit 29 and the FIFO-empty enable is bit 30. Enable bits written as 0, and all enables when there is no write, keep their values.
- R5: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is high while any channel status bit and that channel's enable bit are both set.
- R7: `irq` is high while stall status (bit 13) and stall enable (bit 29) are both set, or while FIFO-empty status (bit 14) and FIFO-empty enable (bit 30) are both set. Either status bit alone, without its enable, does not raise `irq`.
- R8: Bus-error status (bit 15) raises `irq` with no enable involved.
- R9: Bits 10..12, 26..28 and 31 always read 0, and writing 1 to them has no effect.
- R10: A clock edge with `rst_n` low clears every status bit and every enable bit. `irq` is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the cause/enable word |
| wr_data | input | 32 | Write data: 1 clears a status bit, 1 inverts an enable bit |
| rd_data | output | 32 | Current cause/enable word |
| ch_done | input | 10 | Per-channel completion pulses, bit n for channel n |
| stall_evt | input | 1 | Stall event pulse |
| fifo_empty_evt | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_evt | input | 1 | Bus-error event pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a clearing write and a new event landing on the same status bit in the same cycle. It matters because it is where a cause could be lost. The bench drives `wr_en` together with `ch_done` and the side-event pulses on the same edge. It uses a write mask that also clears neighbouring bits, so the bit kept by the event can be seen next to bits the write did clear. The toggle rule depends on the enable state before the write, so the bench keeps its own model of the word. It writes the same mask twice to show an enable turning on and then off again.

// File: rtl/dirq_pkg.sv
// Package: bit layout of the DMA interrupt cause/enable word.
// Assumes a 32-bit word. Per-channel fields start at bit 0 (status) and
// bit 16 (enable), so the channel count must not exceed 13.
package dirq_pkg;
    localparam int WORD_W      = 32;
    localparam int MAX_CH      = 13;
    localparam int ST_STALL    = 13;
    localparam int ST_FEMPTY   = 14;
    localparam int ST_BUSERR   = 15;
    localparam int EN_CH_BASE  = 16;
    localparam int EN_STALL    = 29;
    localparam int EN_FEMPTY   = 30;

    // Mask of the bits that exist for a given channel count.
    function automatic logic [WORD_W-1:0] used_mask(input int nch);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < nch; i++) begin
            m[i]              = 1'b1;
            m[EN_CH_BASE + i] = 1'b1;
        end
        m[ST_STALL]  = 1'b1;
        m[ST_FEMPTY] = 1'b1;
        m[ST_BUSERR] = 1'b1;
        m[EN_STALL]  = 1'b1;
        m[EN_FEMPTY] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/dirq_sticky.sv
// Module: bank of sticky status flags.
// Each flag is set by its event input and cleared by its clear input.
// When both arrive in the same cycle the event wins.
// Assumes single-cycle event pulses and a synchronous active-low reset.
module dirq_sticky #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        // Hold, clear on request, and let an event override a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_i[i])
                q[i] <= 1'b1;
            else if (clr_i[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dirq_toggle.sv
// Module: bank of enable flags that invert when their flip input is 1.
// Assumes flip_i is already gated by the write strobe.
module dirq_toggle #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_en
        // Invert the enable on a 1 in the flip vector, otherwise hold it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (flip_i[i])
                q[i] <= ~q[i];
        end
    end
endmodule

// File: rtl/dirq_reduce.sv
// Module: combines status and enable flags into the interrupt level.
// Bus-error status has no enable and always reaches the output.
module dirq_reduce #(
    parameter int NCH = 10
) (
    input  logic [NCH-1:0] ch_st,
    input  logic [NCH-1:0] ch_en,
    input  logic           stall_st,
    input  logic           stall_en,
    input  logic           fe_st,
    input  logic           fe_en,
    input  logic           berr_st,
    output logic           irq
);
    logic ch_hit;

    // Any channel with both its status and its enable set.
    always_comb ch_hit = |(ch_st & ch_en);

    // OR of every cause that is allowed through.
    always_comb irq = ch_hit | (stall_st & stall_en) | (fe_st & fe_en) | berr_st;
endmodule

// File: rtl/dma_irq_ctrl.sv
// Module: DMA interrupt cause/enable word and interrupt request.
// The status flags (channels, stall, FIFO empty, bus error) are cleared by
// writing 1. The enable flags (channels, stall, FIFO empty) invert when
// written with 1. Bits that do not exist read 0.
// Assumes NCH <= 13 and single-cycle event pulses. rd_data is combinational
// from the registers.
module dma_irq_ctrl
    import dirq_pkg::*;
#(
    parameter int NCH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NCH-1:0]    ch_done,
    input  logic              stall_evt,
    input  logic              fifo_empty_evt,
    input  logic              bus_err_evt,
    output logic              irq
);
    localparam int ST_W = NCH + 3;
    localparam int EN_W = NCH + 2;
    localparam logic [WORD_W-1:0] USED = used_mask(NCH);

    logic [ST_W-1:0] st_set, st_clr, st_q;
    logic [EN_W-1:0] en_flip, en_q;
    logic            unused_wr_bits;

    // Event vector, ordered channels, stall, FIFO empty, bus error.
    always_comb st_set = {bus_err_evt, fifo_empty_evt, stall_evt, ch_done};

    // Clear vector taken from the write data at the status positions.
    always_comb st_clr = wr_en ? {wr_data[ST_BUSERR], wr_data[ST_FEMPTY],
                                  wr_data[ST_STALL], wr_data[NCH-1:0]} : '0;

    // Flip vector taken from the write data at the enable positions.
    always_comb en_flip = wr_en ? {wr_data[EN_FEMPTY], wr_data[EN_STALL],
                                   wr_data[EN_CH_BASE +: NCH]} : '0;

    // Write-data bits that map to no register.
    always_comb unused_wr_bits = &{1'b0, wr_data & ~USED};

    dirq_sticky #(.W(ST_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .clr_i (st_clr),
        .q     (st_q)
    );

    dirq_toggle #(.W(EN_W)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip_i (en_flip),
        .q      (en_q)
    );

    dirq_reduce #(.NCH(NCH)) u_reduce (
        .ch_st    (st_q[NCH-1:0]),
        .ch_en    (en_q[NCH-1:0]),
        .stall_st (st_q[NCH]),
        .stall_en (en_q[NCH]),
        .fe_st    (st_q[NCH+1]),
        .fe_en    (en_q[NCH+1]),
        .berr_st  (st_q[NCH+2]),
        .irq      (irq)
    );

    // Build the read word; positions that map to no flag stay 0.
    always_comb begin
        rd_data                       = '0;
        rd_data[NCH-1:0]              = st_q[NCH-1:0];
        rd_data[ST_STALL]             = st_q[NCH];
        rd_data[ST_FEMPTY]            = st_q[NCH+1];
        rd_data[ST_BUSERR]            = st_q[NCH+2];
        rd_data[EN_CH_BASE +: NCH]    = en_q[NCH-1:0];
        rd_data[EN_STALL]             = en_q[NCH];
        rd_data[EN_FEMPTY]            = en_q[NCH+1];
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
// Module: assertion checker for dma_irq_ctrl, attached with bind.
// Observes the top-level ports only.
module dma_irq_ctrl_chk
    import dirq_pkg::*;
#(
    parameter int NCH = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic [NCH-1:0]    ch_done,
    input logic              stall_evt,
    input logic              fifo_empty_evt,
    input logic              bus_err_evt,
    input logic              irq
);
    localparam logic [WORD_W-1:0] UNUSED = ~used_mask(NCH);

    logic [2:0] side_evt;
    logic       unused_chk_bits;

    always_comb side_evt = {bus_err_evt, fifo_empty_evt, stall_evt};
    always_comb unused_chk_bits = &{1'b0, wr_data};

    // R1
    ch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done != '0) |=> ((rd_data[NCH-1:0] & $past(ch_done)) == $past(ch_done)));

    // R2
    side_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (side_evt != 3'b0) |=> ((rd_data[ST_BUSERR:ST_STALL] & $past(side_evt)) == $past(side_evt)));

    // R3
    ch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data[NCH-1:0] & $past(wr_data[NCH-1:0]) & ~$past(ch_done)) == '0));

    // R4
    en_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[EN_CH_BASE +: NCH] ==
                   $past(rd_data[EN_CH_BASE +: NCH] ^ wr_data[EN_CH_BASE +: NCH])));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[WORD_W-1:EN_CH_BASE]));

    // R8
    buserr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[ST_BUSERR] |-> irq);

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & UNUSED) == '0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !irq));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .ch_done        (ch_done),
    .stall_evt      (stall_evt),
    .fifo_empty_evt (fifo_empty_evt),
    .bus_err_evt    (bus_err_evt),
    .irq            (irq)
);

// File: tb/sim_dma_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_irq_ctrl;
    localparam int NCH = 10;
    localparam logic [31:0] USED = 32'h6000_0000 | (32'((1 << NCH) - 1) << 16)
                                 | 32'h0000_E000 | 32'((1 << NCH) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NCH-1:0] ch_done = '0;
    logic        stall_evt = 1'b0, fifo_empty_evt = 1'b0, bus_err_evt = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] model = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dma_irq_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ch_done(ch_done), .stall_evt(stall_evt),
        .fifo_empty_evt(fifo_empty_evt), .bus_err_evt(bus_err_evt), .irq(irq)
    );

    function automatic logic model_irq(input logic [31:0] m);
        return (|(m[NCH-1:0] & m[16 +: NCH])) | (m[13] & m[29]) |
               (m[14] & m[30]) | m[15];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; the model applies the rules, then word and irq are compared.
    task automatic step(input string req, input logic we, input logic [31:0] wd,
                        input logic [NCH-1:0] ch, input logic [2:0] side);
        logic [31:0] setv, clrv, flip;
        @(negedge clk);
        wr_en = we; wr_data = wd; ch_done = ch;
        {bus_err_evt, fifo_empty_evt, stall_evt} = side;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ch_done = '0;
        {bus_err_evt, fifo_empty_evt, stall_evt} = 3'b0;
        setv = '0; setv[NCH-1:0] = ch; setv[15:13] = side;
        clrv = we ? (wd & 32'h0000_E3FF & USED) : '0;
        flip = we ? (wd & 32'h63FF_0000 & USED) : '0;
        model = (model & ~clrv) | setv;
        model = model ^ flip;
        chk(req, rd_data, model);
        chk({req, " irq"}, {31'b0, irq}, {31'b0, model_irq(model)});
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; model = '0;
        chk("R10 reset word", rd_data, 32'h0);
        chk("R10 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_channels;
        step("R1 ch0", 1'b0, '0, 10'h001, 3'b0);
        step("R1 ch9 and ch4", 1'b0, '0, 10'h210, 3'b0);
        step("R1 sticky idle", 1'b0, '0, '0, 3'b0);
    endtask

    task automatic t_side;
        step("R2 stall", 1'b0, '0, '0, 3'b001);
        step("R2 fifo empty", 1'b0, '0, '0, 3'b010);
        step("R7 status without enable", 1'b0, '0, '0, 3'b0);
    endtask

    task automatic t_clear;
        step("R3 clear ch4 stall fifo", 1'b1, 32'h0000_6010, '0, 3'b0);
        step("R3 zero write keeps", 1'b1, 32'h0, '0, 3'b0);
        step("R3 clear rest", 1'b1, 32'h0000_E3FF, '0, 3'b0);
    endtask

    task automatic t_toggle_irq;
        step("R4 enable ch3", 1'b1, 32'h0008_0000, '0, 3'b0);
        step("R6 ch2 not enabled", 1'b0, '0, 10'h004, 3'b0);
        step("R6 ch3 enabled irq", 1'b0, '0, 10'h008, 3'b0);
        step("R4 toggle ch3 off", 1'b1, 32'h0008_0000, '0, 3'b0);
        step("R3 ack channels", 1'b1, 32'h0000_03FF, '0, 3'b0);
        step("R4 enable stall fifo", 1'b1, 32'h6000_0000, '0, 3'b0);
        step("R7 stall irq", 1'b0, '0, '0, 3'b001);
        step("R3 ack stall", 1'b1, 32'h0000_2000, '0, 3'b0);
        step("R7 fifo irq", 1'b0, '0, '0, 3'b010);
        step("R4 disable both", 1'b1, 32'h6000_4000, '0, 3'b0);
    endtask

    task automatic t_buserr;
        step("R8 bus error no enable", 1'b0, '0, '0, 3'b100);
        step("R8 ack bus error", 1'b1, 32'h0000_8000, '0, 3'b0);
    endtask

    task automatic t_collision;
        step("R5 ch1 event and clear", 1'b1, 32'h0000_0003, 10'h003, 3'b0);
        step("R5 clear neighbour", 1'b1, 32'h0000_E003, 10'h002, 3'b101);
        step("R3 cleanup", 1'b1, 32'h0000_E3FF, '0, 3'b0);
    endtask

    task automatic t_unused;
        step("R9 write unused ones", 1'b1, 32'h9C00_1C00, '0, 3'b0);
        chk("R9 unused read zero", rd_data & ~USED, 32'h0);
        step("R9 all ones", 1'b1, 32'hFFFF_FFFF, '0, 3'b0);
        chk("R9 unused after all ones", rd_data & ~USED, 32'h0);
        t_reset();
        chk("R10 enables cleared", rd_data & 32'hFFFF_0000, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_channels();
        t_side();
        t_clear();
        t_toggle_irq();
        t_buserr();
        t_collision();
        t_unused();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule